// File: doc/BRIEF.md
# Block-Structured Frame Entry and Exit Engine

This engine carries out the stack work of entering and leaving a procedure in a block-structured language. It holds a frame pointer and a stack pointer. It works on a 32-bit stack in word memory that grows toward lower addresses. An entry command carries a local-storage byte count and a lexical nesting level. The engine saves the old frame pointer. For a nested level, it copies the chain of enclosing frame pointers, called the display, out of the caller's frame. It records the new frame base and reserves the local storage. An exit command releases the current frame and restores the caller's frame pointer.

All memory traffic goes through a single request/ready port, one 32-bit word per transfer. Each step waits as long as the memory holds its ready low. A host sequencer issues a command while the engine is idle. It then waits for the one-cycle completion pulse, and at that point the new register values are visible.

Top module: `frame_engine`

## Requirements
- R1: Once reset is released, `sp_q` equals parameter SP_RESET, `fp_q` equals FP_RESET, and `busy`, `done` and `mem_req` are all low.
- R2: An entry command at level 0 does exactly one write: the old `fp_q` goes to address `sp_q-4`. The new `fp_q` is `sp_q-4`, and the new `sp_q` is that value minus the storage count.
- R3: An entry at level L from 1 to 31 first does the level-0 write at address T = `sp_q-4`. It then, for k = 1 to L-1 in increasing order, reads the word at old `fp_q-4k` and pushes it at the next lower word. Last, it pushes T. The new `fp_q` is T, and the new `sp_q` is the address of that last push minus the storage count.
- R4: The level used is `cmd_depth` modulo 32, i.e. bits [4:0] only. For example, 33 acts as 1 and 64 acts as 0.
- R5: The 16-bit storage count is zero-extended, and the stack-pointer subtraction wraps modulo 2^32.
- R6: An exit command reads the word at address `fp_q`. The new `fp_q` is that word, the new `sp_q` is the old `fp_q+4`, and no memory write occurs.
- R7: `mem_req` (with `mem_we` high for a write) holds `mem_addr`, `mem_we` and `mem_wdata` stable until a rising edge at which `mem_ready` is high. That edge completes the transfer, and read data is taken on it.
- R8: A command is taken only when `busy` is low. `cmd_valid` while `busy` is high has no effect on registers, memory or later activity.
- R9: `sp_q` and `fp_q` change only in the cycle where `done` is high. `done` is a one-cycle pulse, and `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_leave | input | 1 | 1 = frame exit, 0 = frame entry |
| cmd_depth | input | 8 | Lexical nesting level (used modulo 32) |
| cmd_alloc | input | 16 | Local storage byte count for entry |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes at an edge where high |
| sp_q | output | 32 | Stack pointer |
| fp_q | output | 32 | Frame pointer |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the memory answers every request eventually and never raises `mem_ready` without a pending request. The bench memory model meets this: it raises ready only while `mem_req` is high, after a programmable count of wait cycles. The properties also assume stack addresses stay word aligned and within the modelled 4 KB window. The stimulus starts from aligned reset pointers and releases every frame it opens, so each pointer stays inside that range. The one exception is the wrap case, which is followed only by an exit.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_OLD,
    ST_FETCH,
    ST_STORE,
    ST_PUSH_NEW,
    ST_POP,
    ST_COMMIT
  } fe_state_e;
endpackage

// File: rtl/fe_seq.sv
module fe_seq
  import fe_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_leave,
  input  logic [LVL_W-1:0] cmd_level,
  input  logic             xfer,
  output fe_state_e        state,
  output logic             op_leave,
  output logic             busy
);
  localparam logic [LVL_W-1:0] ONE  = {{(LVL_W-1){1'b0}}, 1'b1};
  localparam logic [LVL_W-1:0] ZERO = '0;

  fe_state_e        state_q, state_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic             zero_q, zero_d;
  logic             leave_q, leave_d;
  logic             en;

  assign en = (state_q != ST_IDLE) || cmd_valid;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    zero_d  = zero_q;
    leave_d = leave_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) begin
        leave_d = cmd_leave;
        zero_d  = (cmd_level == ZERO);
        cnt_d   = cmd_level - ONE;
        state_d = cmd_leave ? ST_POP : ST_PUSH_OLD;
      end
      ST_PUSH_OLD: if (xfer) begin
        if (zero_q)             state_d = ST_COMMIT;
        else if (cnt_q == ZERO) state_d = ST_PUSH_NEW;
        else                    state_d = ST_FETCH;
      end
      ST_FETCH: if (xfer) state_d = ST_STORE;
      ST_STORE: if (xfer) begin
        cnt_d   = cnt_q - ONE;
        state_d = (cnt_q == ONE) ? ST_PUSH_NEW : ST_FETCH;
      end
      ST_PUSH_NEW, ST_POP: if (xfer) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      zero_q  <= 1'b0;
      leave_q <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      zero_q  <= zero_d;
      leave_q <= leave_d;
    end
  end

  assign state    = state_q;
  assign op_leave = leave_q;
  assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/fe_bus.sv
module fe_bus
  import fe_pkg::*;
#(
  parameter int AW = 32
) (
  input  fe_state_e       state,
  input  logic [AW-1:0]   wsp,
  input  logic [AW-1:0]   wfp,
  input  logic [AW-1:0]   tmp,
  input  logic [AW-1:0]   data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata
);
  localparam logic [AW-1:0] STEP = AW'(4);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = wsp;
    mem_wdata = tmp;
    unique case (state)
      ST_PUSH_OLD: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wsp - STEP; mem_wdata = wfp;
      end
      ST_FETCH: begin
        mem_req = 1'b1; mem_addr = wfp - STEP;
      end
      ST_STORE: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wsp - STEP; mem_wdata = data;
      end
      ST_PUSH_NEW: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = wsp - STEP; mem_wdata = tmp;
      end
      ST_POP: begin
        mem_req = 1'b1; mem_addr = wsp;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fe_dpath.sv
module fe_dpath
  import fe_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          ALLOC_W  = 16,
  parameter logic [31:0] SP_RESET = 32'h0000_1000,
  parameter logic [31:0] FP_RESET = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fe_state_e          state,
  input  logic               op_leave,
  input  logic               cmd_valid,
  input  logic               cmd_leave,
  input  logic [ALLOC_W-1:0] cmd_alloc,
  input  logic               xfer,
  input  logic [AW-1:0]      mem_rdata,
  output logic [AW-1:0]      wsp,
  output logic [AW-1:0]      wfp,
  output logic [AW-1:0]      tmp,
  output logic [AW-1:0]      data,
  output logic [AW-1:0]      sp_q,
  output logic [AW-1:0]      fp_q,
  output logic               done
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0]      wsp_q, wsp_d, wfp_q, wfp_d, tmp_q, tmp_d, data_q, data_d;
  logic [AW-1:0]      sp_r, sp_d, fp_r, fp_d;
  logic [ALLOC_W-1:0] alloc_q, alloc_d;
  logic               done_q, done_d;
  logic               en;

  assign en = (state != ST_IDLE) || cmd_valid || done_q;

  always_comb begin
    wsp_d   = wsp_q;
    wfp_d   = wfp_q;
    tmp_d   = tmp_q;
    data_d  = data_q;
    alloc_d = alloc_q;
    sp_d    = sp_r;
    fp_d    = fp_r;
    done_d  = 1'b0;
    unique case (state)
      ST_IDLE: if (cmd_valid) begin
        wsp_d   = cmd_leave ? fp_r : sp_r;
        wfp_d   = fp_r;
        alloc_d = cmd_alloc;
      end
      ST_PUSH_OLD: if (xfer) begin
        wsp_d = wsp_q - STEP;
        tmp_d = wsp_q - STEP;
      end
      ST_FETCH: if (xfer) begin
        wfp_d  = wfp_q - STEP;
        data_d = mem_rdata;
      end
      ST_STORE, ST_PUSH_NEW: if (xfer) wsp_d = wsp_q - STEP;
      ST_POP: if (xfer) begin
        tmp_d = mem_rdata;
        wsp_d = wsp_q + STEP;
      end
      ST_COMMIT: begin
        sp_d   = op_leave ? wsp_q : wsp_q - {{(AW-ALLOC_W){1'b0}}, alloc_q};
        fp_d   = tmp_q;
        done_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsp_q   <= '0;
      wfp_q   <= '0;
      tmp_q   <= '0;
      data_q  <= '0;
      alloc_q <= '0;
      sp_r    <= AW'(SP_RESET);
      fp_r    <= AW'(FP_RESET);
      done_q  <= 1'b0;
    end else if (en) begin
      wsp_q   <= wsp_d;
      wfp_q   <= wfp_d;
      tmp_q   <= tmp_d;
      data_q  <= data_d;
      alloc_q <= alloc_d;
      sp_r    <= sp_d;
      fp_r    <= fp_d;
      done_q  <= done_d;
    end
  end

  assign wsp  = wsp_q;
  assign wfp  = wfp_q;
  assign tmp  = tmp_q;
  assign data = data_q;
  assign sp_q = sp_r;
  assign fp_q = fp_r;
  assign done = done_q;
endmodule

// File: rtl/frame_engine.sv
module frame_engine
  import fe_pkg::*;
#(
  parameter int          ALLOC_W  = 16,
  parameter int          DEPTH_W  = 8,
  parameter int          LVL_W    = 5,
  parameter logic [31:0] SP_RESET = 32'h0000_1000,
  parameter logic [31:0] FP_RESET = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic               cmd_leave,
  input  logic [DEPTH_W-1:0] cmd_depth,
  input  logic [ALLOC_W-1:0] cmd_alloc,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_ready,
  output logic [31:0]        sp_q,
  output logic [31:0]        fp_q,
  output logic               busy,
  output logic               done
);
  localparam int AW = 32;

  fe_state_e        state;
  logic             op_leave;
  logic             xfer;
  logic [LVL_W-1:0] level;
  logic [AW-1:0]    wsp, wfp, tmp, data;

  assign level = LVL_W'(cmd_depth);
  assign xfer  = mem_req && mem_ready;

  fe_seq #(.LVL_W(LVL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_leave(cmd_leave),
    .cmd_level(level), .xfer(xfer), .state(state), .op_leave(op_leave), .busy(busy)
  );

  fe_dpath #(.AW(AW), .ALLOC_W(ALLOC_W), .SP_RESET(SP_RESET), .FP_RESET(FP_RESET)) u_dpath (
    .clk(clk), .rst_n(rst_n), .state(state), .op_leave(op_leave),
    .cmd_valid(cmd_valid), .cmd_leave(cmd_leave), .cmd_alloc(cmd_alloc),
    .xfer(xfer), .mem_rdata(mem_rdata), .wsp(wsp), .wfp(wfp), .tmp(tmp),
    .data(data), .sp_q(sp_q), .fp_q(fp_q), .done(done)
  );

  fe_bus #(.AW(AW)) u_bus (
    .state(state), .wsp(wsp), .wfp(wfp), .tmp(tmp), .data(data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] sp_q,
  input logic [31:0] fp_q
);
  // R7: a stalled request keeps its address, direction and data
  assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R8: a command seen while idle starts work
  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);

  // R9: pointer registers move only with the completion pulse
  assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(sp_q) && $stable(fp_q)));

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: busy drops exactly when done is raised
  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind frame_engine fe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .sp_q(sp_q), .fp_q(fp_q)
);

// File: tb/tb_frame_engine.sv
module tb_frame_engine;
  logic        clk, rst_n;
  logic        cmd_valid, cmd_leave;
  logic [7:0]  cmd_depth;
  logic [15:0] cmd_alloc;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] sp_q, fp_q;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;
  int lat    = 0;
  int wcnt   = 0;
  logic finished = 1'b0;

  logic [31:0] mem  [0:1023];
  logic [31:0] rmem [0:1023];
  logic [31:0] ref_sp, ref_fp;

  frame_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_leave(cmd_leave),
    .cmd_depth(cmd_depth), .cmd_alloc(cmd_alloc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .sp_q(sp_q), .fp_q(fp_q), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model with programmable wait states
  assign mem_ready = mem_req && (wcnt >= lat);
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (mem_req && mem_ready) begin
      wcnt <= 0;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end else if (mem_req) wcnt <= wcnt + 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ref_enter(input logic [7:0] depth, input logic [15:0] alloc);
    logic [31:0] sp, fp, t, v;
    int lvl;
    lvl = int'(depth % 8'd32);
    sp = ref_sp; fp = ref_fp;
    sp = sp - 4; rmem[sp[11:2]] = fp; t = sp;
    if (lvl > 0) begin
      for (int k = 1; k < lvl; k++) begin
        fp = fp - 4; v = rmem[fp[11:2]];
        sp = sp - 4; rmem[sp[11:2]] = v;
      end
      sp = sp - 4; rmem[sp[11:2]] = t;
    end
    ref_fp = t;
    ref_sp = sp - {16'h0, alloc};
  endtask

  task automatic ref_leave();
    logic [31:0] sp;
    sp = ref_fp;
    ref_fp = rmem[sp[11:2]];
    ref_sp = sp + 4;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== rmem[i]) bad++;
    chk(req, "memory words differing", 32'(bad), 32'd0);
  endtask

  // issue one command, wait for done, check registers, pulse and memory
  task automatic run_cmd(input string req, input logic leave, input logic [7:0] depth,
                         input logic [15:0] alloc);
    logic [31:0] sp0, fp0;
    int n = 0;
    int moved = 0;
    sp0 = sp_q; fp0 = fp_q;
    if (leave) ref_leave(); else ref_enter(depth, alloc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_leave = leave; cmd_depth = depth; cmd_alloc = alloc;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && n < 2000) begin
      if (sp_q !== sp0 || fp_q !== fp0) moved++;
      @(negedge clk); n++;
    end
    chk("R9", "pointer change before done", 32'(moved), 32'd0);
    chk("R9", "done seen", {31'b0, done}, 32'd1);
    chk("R9", "busy low with done", {31'b0, busy}, 32'd0);
    chk(req, "sp_q", sp_q, ref_sp);
    chk(req, "fp_q", fp_q, ref_fp);
    @(negedge clk);
    chk("R9", "done width one cycle", {31'b0, done}, 32'd0);
    cmp_mem(req);
  endtask

  task automatic t_reset();
    chk("R1", "sp_q reset", sp_q, 32'h0000_1000);
    chk("R1", "fp_q reset", fp_q, 32'h0000_1000);
    chk("R1", "busy reset", {31'b0, busy}, 32'd0);
    chk("R1", "done reset", {31'b0, done}, 32'd0);
    chk("R1", "mem_req reset", {31'b0, mem_req}, 32'd0);
  endtask

  task automatic t_flat();
    lat = 0;
    run_cmd("R2", 1'b0, 8'd0, 16'd16);
    chk("R2", "saved old fp", mem[(32'h1000 - 4) >> 2], 32'h0000_1000);
  endtask

  task automatic t_nested();
    run_cmd("R3", 1'b0, 8'd1, 16'd8);
    run_cmd("R3", 1'b0, 8'd3, 16'd0);
  endtask

  task automatic t_leave();
    run_cmd("R6", 1'b1, 8'd0, 16'd0);
    run_cmd("R6", 1'b1, 8'd0, 16'd0);
    run_cmd("R6", 1'b1, 8'd0, 16'd0);
    chk("R6", "back to start sp", sp_q, 32'h0000_1000);
  endtask

  task automatic t_level_mod();
    run_cmd("R4", 1'b0, 8'd33, 16'd4);
    run_cmd("R4", 1'b0, 8'd64, 16'd0);
    run_cmd("R4", 1'b1, 8'd0, 16'd0);
    run_cmd("R4", 1'b1, 8'd0, 16'd0);
  endtask

  task automatic t_wait_states();
    lat = 3;
    run_cmd("R7", 1'b0, 8'd2, 16'd12);
    run_cmd("R7", 1'b1, 8'd0, 16'd0);
    lat = 0;
  endtask

  task automatic t_busy_ignore();
    logic [31:0] sp1;
    lat = 2;
    ref_enter(8'd4, 16'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_leave = 1'b0; cmd_depth = 8'd4; cmd_alloc = 16'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_leave = 1'b1; cmd_alloc = 16'h00F0;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int n = 0; n < 2000 && !done; n++) @(negedge clk);
    chk("R8", "sp after ignored cmd", sp_q, ref_sp);
    chk("R8", "fp after ignored cmd", fp_q, ref_fp);
    sp1 = sp_q;
    repeat (10) @(negedge clk);
    chk("R8", "idle after ignored cmd", {31'b0, busy}, 32'd0);
    chk("R8", "sp still", sp_q, sp1);
    cmp_mem("R8");
    lat = 0;
    run_cmd("R6", 1'b1, 8'd0, 16'd0);
  endtask

  task automatic t_max_level();
    lat = 1;
    run_cmd("R3", 1'b0, 8'd1, 16'd0);
    run_cmd("R3", 1'b0, 8'd2, 16'd0);
    run_cmd("R3", 1'b0, 8'd31, 16'd8);
    run_cmd("R6", 1'b1, 8'd0, 16'd0);
    run_cmd("R6", 1'b1, 8'd0, 16'd0);
    run_cmd("R6", 1'b1, 8'd0, 16'd0);
    lat = 0;
  endtask

  task automatic t_alloc_wrap();
    run_cmd("R5", 1'b0, 8'd0, 16'hFFFF);
    chk("R5", "wrapped sp", sp_q, 32'h0000_0FFC - 32'h0000_FFFF);
    run_cmd("R5", 1'b1, 8'd0, 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 32'hA500_0000 | 32'(i);
      rmem[i] = 32'hA500_0000 | 32'(i);
    end
    ref_sp = 32'h0000_1000; ref_fp = 32'h0000_1000;
    cmd_valid = 1'b0; cmd_leave = 1'b0; cmd_depth = '0; cmd_alloc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_nested();
    t_leave();
    t_level_mod();
    t_wait_states();
    t_busy_ignore();
    t_max_level();
    t_alloc_wrap();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule